// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data for a processor. Each of its two channels holds a source address, a destination address, a unit count and a control word, and all of them sit behind a 32-bit register port. When a channel is ready the block takes the memory bus. For every transfer it issues one read at the source address and then one write of the same data at the destination address. A transfer is 1, 2 or 4 bytes wide. After each transfer the address on each side either steps up, steps down or stays where it is.

A channel can start in one of three ways: on software alone, on a pulse from a UART request line, or on a pulse from an external request line. Work is counted in units. A unit is one transfer, or four back-to-back transfers when burst mode is on. A software-started channel can also be told to run all of its units in one go, without letting go of the bus. When the count reaches zero, or when software stops the channel and asks for notice, the channel pulses its interrupt line. When both channels are ready at once, channel 0 goes first. A unit that has started always runs to its end.

Top module: `dual_dma_ctrl`

## Requirements
- R1: The register address is `reg_addr[2]` for the channel and `reg_addr[1:0]` for the register: 0 source, 1 destination, 2 count, 3 control. A written source or destination keeps bits [27:1], and bit 0 reads back as 0. A written count keeps bits [26:0]. Control reads back bits [15:0], and the bits above read as zero.
- R2: Control bit 0 is the enable and bit 1 is the busy flag. The value written to bit 1 is ignored. A control write with bit 0 low clears both enable and busy.
- R3: Control bits [3:2] pick the trigger. 0 runs whenever the channel is enabled and the count is nonzero. 1 never runs. 2 starts one unit while `req_uart` of that channel is high with the engine idle. 3 does the same with `req_ext`.
- R4: Control bits [13:12] give the transfer size as 2^field bytes, and `bus_size` carries the field. A field value of 3 makes the channel never transfer.
- R5: Each transfer is a read at the source with `bus_we` low, then a write at the destination with `bus_we` high that carries the read data. A bus access completes in the cycle where `bus_valid` and `bus_ready` are both high.
- R6: After each transfer, bit 7 holds the source and bit 6 holds the destination. Otherwise bit 5 (source) or bit 4 (destination) makes that address step down by the size, and without it the address steps up by the size. A step down is skipped when the address is below the size. A step up is skipped when the result would exceed 0x0FFFFFFE. Byte steps may leave an address odd.
- R7: With control bit 9 set, a unit is four transfers. Otherwise a unit is one transfer. The count drops by one per unit.
- R8: With control bit 14 set and trigger 0, units follow one another without releasing the bus until the count is zero, even if channel 0 becomes ready during the run.
- R9: When the count reaches zero, control bits [1:0] clear and `irq` of that channel is high for exactly one cycle, in the cycle after the final write.
- R10: A control write with bit 0 low and bit 8 high pulses `irq` of that channel for one cycle. The same write with bit 8 low gives no pulse.
- R11: When both channels are ready with the engine idle, channel 0 is served first. A unit in progress is never interrupted by the other channel.
- R12: Busy sets when a unit starts. It stays set between units until completion or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Channel and register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_uart | input | 2 | UART request, one per channel |
| req_ext | input | 2 | External request, one per channel |
| bus_valid | output | 1 | Bus access pending |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 28 | Bus byte address |
| bus_size | output | 2 | Size field, 2^field bytes |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access completes this cycle |
| irq | output | 2 | Per-channel interrupt pulse |

## Verification
The bench stalls the bus on every third cycle and checks each access against a queue of predicted addresses, directions and sizes.

- Address limits: a source at 2 stepping down by 2 must stop at 0, and a destination at 0x0FFFFFFC must stay put. A design that wrapped or stepped the wrong way shows a wrong address on the bus.
- Burst and continuous runs: a broken burst counter shows the wrong number of accesses. A design that re-arbitrated between continuous units would let channel 0 cut into channel 1's run.
- Channels that must stay quiet: the illegal size and the invalid trigger must produce no bus access at all.
- Interrupts: the stop interrupt must pulse only when bit 8 is set, and the busy flag must survive between request-started units.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W    = 28;
  localparam int CNT_W     = 27;
  localparam int DATA_W    = 32;
  localparam int CTL_W     = 16;
  localparam int BURST_LEN = 4;

  localparam int B_EN      = 0;
  localparam int B_BUSY    = 1;
  localparam int B_DDEC    = 4;
  localparam int B_SDEC    = 5;
  localparam int B_DHOLD   = 6;
  localparam int B_SHOLD   = 7;
  localparam int B_STOPIRQ = 8;
  localparam int B_BURST   = 9;
  localparam int SZ_LO     = 12;
  localparam int SZ_HI     = 13;
  localparam int B_CONT    = 14;

  localparam logic [ADDR_W-1:0] ADDR_TOP = 28'hFFF_FFFE;

  typedef enum logic [1:0] {TRIG_SW, TRIG_OFF, TRIG_UART, TRIG_EXT} trig_e;
  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

  function automatic logic [ADDR_W-1:0] size_bytes(input logic [1:0] f);
    return ADDR_W'(1) << f;
  endfunction

  function automatic logic size_ok(input logic [1:0] f);
    return f != 2'd3;
  endfunction

  // Post-transfer address: hold, step down unless below size, step up unless past top.
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] f,
                                                  input logic hold, input logic dec);
    logic [ADDR_W-1:0] b;
    b = size_bytes(f);
    if (hold) return a;
    if (dec) return (a >= b) ? a - b : a;
    return (a <= ADDR_TOP - b) ? a + b : a;
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [1:0]        wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_uart,
  input  logic              req_ext,
  input  logic              unit_start,
  input  logic              xfer_done,
  input  logic              unit_done,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  cnt,
  output logic [CTL_W-1:0]  ctl,
  output logic              ready,
  output logic              last_unit,
  output logic              irq
);
  logic  wr_src, wr_dst, wr_cnt, wr_ctl;
  logic  trig_ok, done_now, stop_now;
  trig_e trig;
  logic  unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:ADDR_W];
  assign wr_src    = sel_we && (wr_off == 2'd0);
  assign wr_dst    = sel_we && (wr_off == 2'd1);
  assign wr_cnt    = sel_we && (wr_off == 2'd2);
  assign wr_ctl    = sel_we && (wr_off == 2'd3);
  assign trig      = trig_e'(ctl[3:2]);

  always_comb begin
    case (trig)
      TRIG_SW:   trig_ok = 1'b1;
      TRIG_UART: trig_ok = req_uart;
      TRIG_EXT:  trig_ok = req_ext;
      default:   trig_ok = 1'b0;
    endcase
  end

  assign ready     = ctl[B_EN] && (cnt != '0) && size_ok(ctl[SZ_HI:SZ_LO]) && trig_ok;
  assign last_unit = (cnt == CNT_W'(1));
  assign done_now  = unit_done && last_unit;
  assign stop_now  = wr_ctl && !wr_data[B_EN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
      ctl <= '0;
      irq <= 1'b0;
    end else begin
      irq <= done_now || (stop_now && wr_data[B_STOPIRQ]);
      if (wr_src)         src <= {wr_data[ADDR_W-1:1], 1'b0};
      else if (xfer_done) src <= next_addr(src, ctl[SZ_HI:SZ_LO], ctl[B_SHOLD], ctl[B_SDEC]);
      if (wr_dst)         dst <= {wr_data[ADDR_W-1:1], 1'b0};
      else if (xfer_done) dst <= next_addr(dst, ctl[SZ_HI:SZ_LO], ctl[B_DHOLD], ctl[B_DDEC]);
      if (wr_cnt)                        cnt <= wr_data[CNT_W-1:0];
      else if (unit_done && cnt != '0)   cnt <= cnt - CNT_W'(1);
      if (wr_ctl)          ctl <= {wr_data[CTL_W-1:2], ctl[B_BUSY] & wr_data[B_EN], wr_data[B_EN]};
      else if (done_now)   ctl[1:0] <= 2'b00;
      else if (unit_start) ctl[B_BUSY] <= 1'b1;
    end
  end

  a_r12_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_start && !wr_ctl) |=> ctl[B_BUSY]);
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_now && !wr_ctl && !wr_cnt) |=> (ctl[1:0] == 2'b00 && irq && cnt == '0));
  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> (!ctl[B_EN] && !ctl[B_BUSY]));
  a_r6_inc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !ctl[B_SHOLD] && !ctl[B_SDEC] && !wr_src && !wr_ctl) |=> (src >= $past(src)));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N  = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             ready,
  input  logic [NCH-1:0][ADDR_W-1:0] src_v,
  input  logic [NCH-1:0][ADDR_W-1:0] dst_v,
  input  logic [NCH-1:0][CTL_W-1:0]  ctl_v,
  input  logic [NCH-1:0]             last_v,
  output logic [NCH-1:0]             unit_start,
  output logic [NCH-1:0]             xfer_done,
  output logic [NCH-1:0]             unit_done,
  output logic                       bus_valid,
  output logic                       bus_we,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic [1:0]                 bus_size,
  output logic [DATA_W-1:0]          bus_wdata,
  input  logic [DATA_W-1:0]          bus_rdata,
  input  logic                       bus_ready
);
  mv_state_e         state;
  logic [CHW-1:0]    cur_ch;
  logic [BEAT_W-1:0] beat;
  logic [DATA_W-1:0] data_q;
  logic [NCH-1:0]    grant;
  logic [CHW-1:0]    gidx;
  logic              gany, hs, last_beat, chain;
  logic [CTL_W-1:0]  cur_ctl;

  dma_prio_arb #(.N(NCH)) u_arb (.req(ready), .grant(grant), .idx(gidx), .any(gany));

  assign cur_ctl   = ctl_v[cur_ch];
  assign bus_valid = (state != MV_IDLE);
  assign bus_we    = (state == MV_WRITE);
  assign bus_addr  = bus_we ? dst_v[cur_ch] : src_v[cur_ch];
  assign bus_size  = cur_ctl[SZ_HI:SZ_LO];
  assign bus_wdata = data_q;
  assign hs        = bus_valid && bus_ready;
  assign last_beat = !cur_ctl[B_BURST] || (beat == BEAT_W'(BURST_LEN - 1));
  assign chain     = cur_ctl[B_CONT] && (trig_e'(cur_ctl[3:2]) == TRIG_SW) &&
                     !last_v[cur_ch] && cur_ctl[B_EN];

  always_comb begin
    unit_start = (state == MV_IDLE) ? grant : '0;
    xfer_done  = '0;
    unit_done  = '0;
    if (state == MV_WRITE && hs) begin
      xfer_done[cur_ch] = 1'b1;
      unit_done[cur_ch] = last_beat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= MV_IDLE;
      cur_ch <= '0;
      beat   <= '0;
      data_q <= '0;
    end else begin
      case (state)
        MV_IDLE: if (gany) begin
          cur_ch <= gidx;
          beat   <= '0;
          state  <= MV_READ;
        end
        MV_READ: if (hs) begin
          data_q <= bus_rdata;
          state  <= MV_WRITE;
        end
        MV_WRITE: if (hs) begin
          if (!last_beat) begin
            beat  <= beat + BEAT_W'(1);
            state <= MV_READ;
          end else if (chain) begin
            beat  <= '0;
            state <= MV_READ;
          end else begin
            state <= MV_IDLE;
          end
        end
        default: state <= MV_IDLE;
      endcase
    end
  end

  a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size != 2'd3));
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !bus_we) |=> (bus_valid && bus_we && bus_wdata == $past(bus_rdata)));
  a_r11_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MV_IDLE && ready[0]) |=> (state == MV_READ && cur_ch == '0));
  a_r11_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(bus_we && bus_ready)) |=> (bus_valid && $stable(cur_ch)));
endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CHW+1:0]    reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    req_uart,
  input  logic [NCH-1:0]    req_ext,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0][ADDR_W-1:0] src_v, dst_v;
  logic [NCH-1:0][CNT_W-1:0]  cnt_v;
  logic [NCH-1:0][CTL_W-1:0]  ctl_v;
  logic [NCH-1:0]             ready_v, last_v, start_v, xdone_v, udone_v;
  logic [CHW-1:0]             reg_ch;
  logic [1:0]                 reg_off;

  assign reg_ch  = reg_addr[CHW+1:2];
  assign reg_off = reg_addr[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n),
      .sel_we(reg_we && (reg_ch == CHW'(g))), .wr_off(reg_off), .wr_data(reg_wdata),
      .req_uart(req_uart[g]), .req_ext(req_ext[g]),
      .unit_start(start_v[g]), .xfer_done(xdone_v[g]), .unit_done(udone_v[g]),
      .src(src_v[g]), .dst(dst_v[g]), .cnt(cnt_v[g]), .ctl(ctl_v[g]),
      .ready(ready_v[g]), .last_unit(last_v[g]), .irq(irq[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_ch == CHW'(i)) begin
        case (reg_off)
          2'd0:    reg_rdata = DATA_W'(src_v[i]);
          2'd1:    reg_rdata = DATA_W'(dst_v[i]);
          2'd2:    reg_rdata = DATA_W'(cnt_v[i]);
          default: reg_rdata = DATA_W'(ctl_v[i]);
        endcase
      end
    end
  end

  dma_mover #(.NCH(NCH)) u_mover (
    .clk(clk), .rst_n(rst_n), .ready(ready_v), .src_v(src_v), .dst_v(dst_v),
    .ctl_v(ctl_v), .last_v(last_v), .unit_start(start_v), .xfer_done(xdone_v),
    .unit_done(udone_v), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );
endmodule

// File: tb/test_dual_dma_ctrl.sv
module test_dual_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  req_uart = '0, req_ext = '0;
  logic        bus_valid, bus_we;
  logic [27:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic [1:0]  irq;

  int tests = 0, fails = 0, cyc = 0;
  int irq_seen[2] = '{0, 0};
  bit stall_en = 1'b1;
  bit finished = 1'b0;
  int unsigned last_rd = 0;

  typedef struct { bit we; int unsigned addr; int unsigned szf; } xact_t;
  xact_t expq[$];

  localparam int unsigned F_DDEC = 1 << 4, F_SDEC = 1 << 5, F_DHOLD = 1 << 6,
                          F_SHOLD = 1 << 7, F_STOPIRQ = 1 << 8, F_BURST = 1 << 9,
                          F_CONT = 1 << 14;

  always #5 clk = ~clk;

  dual_dma_ctrl i_dual_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_uart(req_uart), .req_ext(req_ext), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq)
  );

  function automatic int unsigned pat(input int unsigned a);
    return (a * 32'h0100_0193) ^ 32'hA5A5_5A5A;
  endfunction

  function automatic int unsigned msk(input int unsigned szf);
    if (szf == 0) return 32'hFF;
    if (szf == 1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int unsigned nxt(input int unsigned a, input int unsigned szf,
                                      input bit hold, input bit dec);
    int unsigned b = 1 << szf;
    if (hold) return a;
    if (dec) return (a < b) ? a : a - b;
    return (a + b > 32'h0FFF_FFFE) ? a : a + b;
  endfunction

  function automatic int unsigned mkctl(input bit en, input int unsigned trg,
                                        input int unsigned szf, input int unsigned fl);
    return fl | (szf << 12) | (trg << 2) | 32'(en);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic plan(input int unsigned s, input int unsigned d, input int unsigned szf,
                      input bit sh, input bit sd, input bit dh, input bit dd, input int n,
                      output int unsigned fs, output int unsigned fd);
    for (int k = 0; k < n; k++) begin
      expq.push_back('{we: 1'b0, addr: s, szf: szf});
      expq.push_back('{we: 1'b1, addr: d, szf: szf});
      s = nxt(s, szf, sh, sd);
      d = nxt(d, szf, dh, dd);
    end
    fs = s;
    fd = d;
  endtask

  task automatic reg_write(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(ch * 4 + off); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input int ch, input int off, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 3'(ch * 4 + off);
    #1 v = reg_rdata;
  endtask

  task automatic drain;
    while (expq.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Bus responder and cycle-by-cycle comparison against the predicted access queue.
  always @(negedge clk) begin
    xact_t e;
    cyc++;
    bus_ready = !(stall_en && (cyc % 3 == 1));
    for (int i = 0; i < 2; i++) if (irq[i]) irq_seen[i]++;
    if (rst_n && bus_valid && bus_ready) begin
      tests++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected access actual=%0h expected=none", bus_addr);
      end else begin
        e = expq.pop_front();
        if (e.we != bus_we || e.addr != 32'(bus_addr) || e.szf != 32'(bus_size)) begin
          fails++;
          $display("FAIL R6 access actual=%0b/%0h/%0d expected=%0b/%0h/%0d",
                   bus_we, bus_addr, bus_size, e.we, e.addr, e.szf);
        end
        if (!bus_we) begin
          last_rd   = pat(32'(bus_addr)) & msk(32'(bus_size));
          bus_rdata = last_rd;
        end else if ((bus_wdata & msk(32'(bus_size))) != last_rd) begin
          fails++;
          $display("FAIL R5 write data actual=%0h expected=%0h", bus_wdata, last_rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned fs, fd, c, i0, i1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    for (int ch = 0; ch < 2; ch++)
      for (int off = 0; off < 4; off++) begin
        reg_read(ch, off, v);
        chk("R1 reset value", v, 0);
      end
    chk("R9 irq idle after reset", 32'(irq), 0);
    chk("R5 bus idle after reset", 32'(bus_valid), 0);

    // R1 masking
    reg_write(0, 0, 32'hFFFF_FFFF); reg_read(0, 0, v); chk("R1 source mask", v, 32'h0FFF_FFFE);
    reg_write(1, 1, 32'hFFFF_FFFF); reg_read(1, 1, v); chk("R1 dest mask", v, 32'h0FFF_FFFE);
    reg_write(0, 2, 32'hFFFF_FFFF); reg_read(0, 2, v); chk("R1 count mask", v, 32'h07FF_FFFF);
    reg_write(0, 3, 32'hFFFF_0000); reg_read(0, 3, v); chk("R1 control upper bits", v, 0);

    // R2/R3 invalid trigger, busy bit not writable
    reg_write(0, 2, 4);
    c = mkctl(1, 1, 2, 0);
    reg_write(0, 3, c | 2);
    reg_read(0, 3, v); chk("R2 busy not writable", v, c);
    repeat (20) @(negedge clk);
    reg_read(0, 2, v); chk("R3 invalid trigger never runs", v, 4);
    i0 = irq_seen[0];
    reg_write(0, 3, 0);
    repeat (3) @(negedge clk);
    chk("R10 stop without bit 8 no irq", irq_seen[0] - i0, 0);

    // R4 illegal size
    reg_write(0, 3, mkctl(1, 0, 3, 0));
    repeat (20) @(negedge clk);
    reg_read(0, 2, v); chk("R4 illegal size no transfer", v, 4);
    reg_read(0, 3, v); chk("R4 illegal size not busy", v & 2, 0);
    reg_write(0, 3, 0);

    // R5/R6/R9 basic increment, size 4
    reg_write(0, 0, 32'h100); reg_write(0, 1, 32'h200); reg_write(0, 2, 3);
    plan(32'h100, 32'h200, 2, 0, 0, 0, 0, 3, fs, fd);
    c = mkctl(1, 0, 2, 0); i0 = irq_seen[0];
    reg_write(0, 3, c);
    drain();
    reg_read(0, 2, v); chk("R9 count reaches zero", v, 0);
    reg_read(0, 3, v); chk("R9 enable and busy cleared", v, c & ~32'h3);
    reg_read(0, 0, v); chk("R6 source step up by 4", v, fs);
    reg_read(0, 1, v); chk("R6 dest step up by 4", v, fd);
    chk("R9 one-cycle irq", irq_seen[0] - i0, 1);

    // R6 decrement floor, hold destination
    reg_write(1, 0, 2); reg_write(1, 1, 32'h300); reg_write(1, 2, 2);
    plan(2, 32'h300, 1, 0, 1, 1, 0, 2, fs, fd);
    reg_write(1, 3, mkctl(1, 0, 1, F_SDEC | F_DHOLD));
    drain();
    reg_read(1, 0, v); chk("R6 decrement stops at floor", v, fs);
    reg_read(1, 1, v); chk("R6 destination held", v, fd);

    // R6 increment ceiling
    reg_write(0, 0, 32'h40); reg_write(0, 1, 32'h0FFF_FFFC); reg_write(0, 2, 2);
    plan(32'h40, 32'h0FFF_FFFC, 2, 0, 0, 0, 0, 2, fs, fd);
    reg_write(0, 3, mkctl(1, 0, 2, 0));
    drain();
    reg_read(0, 1, v); chk("R6 increment skipped at top", v, 32'h0FFF_FFFC);

    // R7 burst, byte size, destination decrement
    reg_write(1, 0, 32'h10); reg_write(1, 1, 32'h80); reg_write(1, 2, 2);
    plan(32'h10, 32'h80, 0, 0, 0, 0, 1, 8, fs, fd);
    reg_write(1, 3, mkctl(1, 0, 0, F_BURST | F_DDEC));
    drain();
    reg_read(1, 2, v); chk("R7 count per unit", v, 0);
    reg_read(1, 0, v); chk("R7 eight byte steps source", v, fs);
    reg_read(1, 1, v); chk("R7 eight byte steps dest", v, fd);

    // R3 UART trigger, R12 busy held
    reg_write(0, 0, 32'h500); reg_write(0, 1, 32'h600); reg_write(0, 2, 5);
    reg_write(0, 3, mkctl(1, 2, 2, 0));
    repeat (10) @(negedge clk);
    reg_read(0, 2, v); chk("R3 no request no transfer", v, 5);
    plan(32'h500, 32'h600, 2, 0, 0, 0, 0, 1, fs, fd);
    @(negedge clk); req_uart = 2'b01; @(negedge clk); req_uart = 2'b00;
    drain();
    reg_read(0, 2, v); chk("R3 one unit per request", v, 4);
    reg_read(0, 3, v); chk("R12 busy held between units", v & 3, 3);

    // R10 stop with interrupt
    i0 = irq_seen[0];
    reg_write(0, 3, F_STOPIRQ);
    repeat (3) @(negedge clk);
    chk("R10 stop irq pulse", irq_seen[0] - i0, 1);
    reg_read(0, 3, v); chk("R2 stop clears enable and busy", v & 3, 0);
    i0 = irq_seen[0];
    reg_write(0, 3, 0);
    repeat (3) @(negedge clk);
    chk("R10 plain stop no irq", irq_seen[0] - i0, 0);

    // R3 external trigger on channel 1
    reg_write(1, 0, 32'h700); reg_write(1, 1, 32'h800); reg_write(1, 2, 1);
    reg_write(1, 3, mkctl(1, 3, 1, 0));
    plan(32'h700, 32'h800, 1, 0, 0, 0, 0, 1, fs, fd);
    i1 = irq_seen[1];
    @(negedge clk); req_ext = 2'b10; @(negedge clk); req_ext = 2'b00;
    drain();
    chk("R3 external request completes", irq_seen[1] - i1, 1);

    // R11 priority with both requests held
    reg_write(0, 0, 32'h1000); reg_write(0, 1, 32'h1100); reg_write(0, 2, 2);
    reg_write(1, 0, 32'h2000); reg_write(1, 1, 32'h2100); reg_write(1, 2, 2);
    reg_write(0, 3, mkctl(1, 2, 0, 0));
    reg_write(1, 3, mkctl(1, 2, 0, 0));
    plan(32'h1000, 32'h1100, 0, 0, 0, 0, 0, 2, fs, fd);
    plan(32'h2000, 32'h2100, 0, 0, 0, 0, 0, 2, fs, fd);
    @(negedge clk); req_uart = 2'b11;
    drain();
    req_uart = 2'b00;
    reg_read(1, 2, v); chk("R11 channel 1 served after channel 0", v, 0);

    // R8 continuous run not broken by channel 0
    reg_write(1, 0, 32'h3000); reg_write(1, 1, 32'h3100); reg_write(1, 2, 3);
    reg_write(0, 0, 32'h4000); reg_write(0, 1, 32'h4100); reg_write(0, 2, 1);
    plan(32'h3000, 32'h3100, 2, 0, 0, 0, 0, 3, fs, fd);
    plan(32'h4000, 32'h4100, 2, 0, 0, 0, 0, 1, fs, fd);
    reg_write(1, 3, mkctl(1, 0, 2, F_CONT));
    reg_write(0, 3, mkctl(1, 0, 2, 0));
    drain();
    reg_read(1, 2, v); chk("R8 continuous run completed", v, 0);
    reg_read(0, 2, v); chk("R11 channel 0 after run", v, 0);
    chk("R5 no missing accesses", expq.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule